// File: doc/BRIEF.md
# Register Stack Frame Allocator

This block carries out the frame-allocate step of a register-stack machine. A request gives four sizes: input, local, output and rotating. It also gives the index of the qualifying predicate and the previous-function-state word. The block keeps the current frame marker, which holds the frame size, the local size and the rotating size. It also reads the three rename bases (general, floating, predicate) from the rotation logic. From the operands it works out the new frame size and the new local size. It checks the request against a set of legality rules. If the request is legal, it loads the new marker and returns the previous-function-state word so the pipeline can write it to the destination register. The new frame can grow or shrink the old one.

Physical registers are tracked in a free-register count. When a legal request grows the frame by more registers than are free, the block holds the requester with a valid/ready handshake and raises a stall. Each pulse from the spill engine adds one free register. Once the growth fits, the request retires. A request that shrinks the frame returns the freed registers to the count. A faulting request is accepted at once, reports its fault code, and changes no state.

Top module: `rsf_alloc`

## Requirements
- R1: On a legal accepted request (`req_valid` and `req_ready` high at a rising edge), the marker outputs show frame size = inputs + locals + outputs, local size = inputs + locals, and rotating size = the rotating operand, starting in the cycle after that edge.
- R2: One cycle after every accepted request, `rsp_valid` pulses for exactly one cycle. `rsp_dest` then carries the `pfs_in` value sampled at acceptance if the request succeeded, and zero if it faulted.
- R3: A qualifying predicate index other than 0 gives `rsp_fault` = 1 (illegal operation).
- R4: A frame size above MAX_FRAME (96) gives `rsp_fault` = 1. A frame of exactly 96 is legal.
- R5: A rotating size that is not a multiple of ROT_GRAN (8), or that is larger than the new frame size, gives `rsp_fault` = 1.
- R6: If the rotating size differs from the current rotating size while any rename base is nonzero, the result is `rsp_fault` = 2 (reserved field). A request with an unchanged rotating size passes this check whatever the rename bases hold.
- R7: Fault codes are 0 none, 1 illegal, 2 reserved. When both an illegal condition and the reserved condition hold, the code is 1.
- R8: A faulting request is ready at once, never raises `stall`, and leaves the marker and the free count unchanged.
- R9: A legal request whose growth (new frame size minus current frame size, when positive) exceeds `free_regs` drives `stall` high and `req_ready` low, and the marker stays unchanged while it waits.
- R10: Each cycle with `spill_done` high adds one to `free_regs`. A legal accepted request subtracts its growth from `free_regs`, or adds back the amount by which it shrank the frame.
- R11: A request with every size equal to 0 and the rotating size equal to 0 is legal and leaves an empty frame.
- R12: After reset the marker fields are 0, `free_regs` equals FREE_RST (16), and `rsp_valid` and `stall` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Allocate request present |
| req_ready | output | 1 | Request is taken at this edge |
| op_in | input | SZ_W | Input-region size |
| op_loc | input | SZ_W | Local-region size |
| op_out | input | SZ_W | Output-region size |
| op_rot | input | SZ_W | Rotating-region size |
| op_qp | input | QP_W | Qualifying predicate index |
| pfs_in | input | PFS_W | Previous function state word |
| base_gr | input | GR_W | General rename base |
| base_fr | input | FR_W | Floating rename base |
| base_pr | input | PR_W | Predicate rename base |
| spill_done | input | 1 | One register written to backing store |
| stall | output | 1 | Legal request waiting for free registers |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 2 | Fault code (0 none, 1 illegal, 2 reserved) |
| rsp_dest | output | PFS_W | Value for the destination register |
| cfm_sof | output | SZ_W | Current frame size |
| cfm_sol | output | SZ_W | Current local size |
| cfm_sor | output | SZ_W | Current rotating size |
| free_regs | output | FREE_W | Free physical register count |

## Verification
The frame computation is tried with growth that fits the free count, with growth that uses up the count exactly, with growth that must wait for spills, with a shrink, and with an empty frame. Together these show that the growth, the shrink return and the stall release are each counted correctly. The fault paths are each driven with one condition on its own: a nonzero predicate, a frame of 100 against a legal frame of 96, an uneven rotating size, and a rotating size larger than the frame. Next come each rename base on its own, with the rotating size changed and then with it unchanged. A final case combines an illegal condition with the reserved condition, which separates the fault codes and shows their priority.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_ILLEGAL  = 2'd1,
    FLT_RESERVED = 2'd2
  } flt_e;
endpackage

// File: rtl/rsf_rst_sync.sv
module rsf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rsf_legality.sv
module rsf_legality #(
  parameter int SZ_W      = 7,
  parameter int QP_W      = 6,
  parameter int GR_W      = 7,
  parameter int FR_W      = 7,
  parameter int PR_W      = 6,
  parameter int MAX_FRAME = 96,
  parameter int ROT_GRAN  = 8
) (
  input  logic [SZ_W-1:0]   n_in,
  input  logic [SZ_W-1:0]   n_loc,
  input  logic [SZ_W-1:0]   n_out,
  input  logic [SZ_W-1:0]   n_rot,
  input  logic [QP_W-1:0]   qp,
  input  logic [SZ_W-1:0]   cur_sor,
  input  logic [GR_W-1:0]   base_gr,
  input  logic [FR_W-1:0]   base_fr,
  input  logic [PR_W-1:0]   base_pr,
  output logic [SZ_W+1:0]   new_sof,
  output logic [SZ_W+1:0]   new_sol,
  output rsf_pkg::flt_e     fault
);
  localparam int SUM_W   = SZ_W + 2;
  localparam int GRAN_LG = $clog2(ROT_GRAN);

  logic [SUM_W-1:0] rot_w;
  logic             ill_qp, ill_big, ill_rot, ill_gran, rsv_hit;

  // The granularity check is present only when the rotating unit is above one.
  generate
    if (GRAN_LG > 0) begin : g_gran
      assign ill_gran = (n_rot[GRAN_LG-1:0] != '0);
    end else begin : g_nogran
      assign ill_gran = 1'b0;
    end
  endgenerate

  always_comb begin
    new_sol = SUM_W'(n_in) + SUM_W'(n_loc);
    new_sof = new_sol + SUM_W'(n_out);
    rot_w   = SUM_W'(n_rot);
    ill_qp  = (qp != '0);
    ill_big = (new_sof > SUM_W'(MAX_FRAME));
    ill_rot = (rot_w > new_sof);
    rsv_hit = (n_rot != cur_sor) && ((|base_gr) || (|base_fr) || (|base_pr));
    // Illegal-operation conditions outrank the reserved-field check.
    if (ill_qp || ill_big || ill_rot || ill_gran) fault = rsf_pkg::FLT_ILLEGAL;
    else if (rsv_hit)                             fault = rsf_pkg::FLT_RESERVED;
    else                                          fault = rsf_pkg::FLT_NONE;
  end
endmodule

// File: rtl/rsf_free_pool.sv
module rsf_free_pool #(
  parameter int FREE_W   = 8,
  parameter int NEED_W   = 9,
  parameter int FREE_RST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spill_done,
  input  logic              commit,
  input  logic [NEED_W-1:0] take,
  input  logic [NEED_W-1:0] give,
  input  logic [NEED_W-1:0] need,
  output logic [FREE_W-1:0] free_cnt,
  output logic              enough
);
  localparam int CW       = ((FREE_W > NEED_W) ? FREE_W : NEED_W) + 2;
  localparam int FREE_MAX = (1 << FREE_W) - 1;

  logic [FREE_W-1:0] free_q, free_d;
  logic [CW-1:0]     sum;
  logic              en;

  always_comb begin
    enough = (CW'(need) <= CW'(free_q));
    en     = spill_done | commit;
    sum    = CW'(free_q) + CW'(spill_done);
    if (commit) sum = sum + CW'(give) - CW'(take);
    if (sum > CW'(FREE_MAX)) free_d = FREE_W'(FREE_MAX);
    else                     free_d = sum[FREE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  free_q <= FREE_W'(FREE_RST);
    else if (en) free_q <= free_d;
  end

  assign free_cnt = free_q;
endmodule

// File: rtl/rsf_alloc.sv
module rsf_alloc #(
  parameter int SZ_W      = 7,
  parameter int QP_W      = 6,
  parameter int GR_W      = 7,
  parameter int FR_W      = 7,
  parameter int PR_W      = 6,
  parameter int PFS_W     = 38,
  parameter int FREE_W    = 8,
  parameter int FREE_RST  = 16,
  parameter int MAX_FRAME = 96,
  parameter int ROT_GRAN  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SZ_W-1:0]   op_in,
  input  logic [SZ_W-1:0]   op_loc,
  input  logic [SZ_W-1:0]   op_out,
  input  logic [SZ_W-1:0]   op_rot,
  input  logic [QP_W-1:0]   op_qp,
  input  logic [PFS_W-1:0]  pfs_in,
  input  logic [GR_W-1:0]   base_gr,
  input  logic [FR_W-1:0]   base_fr,
  input  logic [PR_W-1:0]   base_pr,
  input  logic              spill_done,
  output logic              stall,
  output logic              rsp_valid,
  output logic [1:0]        rsp_fault,
  output logic [PFS_W-1:0]  rsp_dest,
  output logic [SZ_W-1:0]   cfm_sof,
  output logic [SZ_W-1:0]   cfm_sol,
  output logic [SZ_W-1:0]   cfm_sor,
  output logic [FREE_W-1:0] free_regs
);
  localparam int SUM_W = SZ_W + 2;

  logic               rst_n_s;
  logic [SUM_W-1:0]   new_sof, new_sol, cur_w, grow, shrink;
  rsf_pkg::flt_e      fault;
  logic               legal, enough, accept, commit;

  logic [SZ_W-1:0]    sof_q, sol_q, sor_q, sof_d, sol_d, sor_d;
  logic               rv_q, rv_d;
  logic [1:0]         rf_q, rf_d;
  logic [PFS_W-1:0]   rd_q, rd_d;

  rsf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  rsf_legality #(
    .SZ_W(SZ_W), .QP_W(QP_W), .GR_W(GR_W), .FR_W(FR_W), .PR_W(PR_W),
    .MAX_FRAME(MAX_FRAME), .ROT_GRAN(ROT_GRAN)
  ) u_legal (
    .n_in    (op_in),
    .n_loc   (op_loc),
    .n_out   (op_out),
    .n_rot   (op_rot),
    .qp      (op_qp),
    .cur_sor (sor_q),
    .base_gr (base_gr),
    .base_fr (base_fr),
    .base_pr (base_pr),
    .new_sof (new_sof),
    .new_sol (new_sol),
    .fault   (fault)
  );

  always_comb begin
    cur_w  = SUM_W'(sof_q);
    grow   = (new_sof > cur_w) ? (new_sof - cur_w) : '0;
    shrink = (cur_w > new_sof) ? (cur_w - new_sof) : '0;
    legal  = (fault == rsf_pkg::FLT_NONE);
  end

  rsf_free_pool #(
    .FREE_W(FREE_W), .NEED_W(SUM_W), .FREE_RST(FREE_RST)
  ) u_pool (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .spill_done (spill_done),
    .commit     (commit),
    .take       (grow),
    .give       (shrink),
    .need       (grow),
    .free_cnt   (free_regs),
    .enough     (enough)
  );

  // Handshake: faults go through at once, legal requests wait for registers.
  always_comb begin
    req_ready = !legal || enough;
    stall     = req_valid && legal && !enough;
    accept    = req_valid && req_ready;
    commit    = accept && legal;
  end

  // Next-state for the marker and the response.
  always_comb begin
    sof_d = sof_q;
    sol_d = sol_q;
    sor_d = sor_q;
    if (commit) begin
      sof_d = new_sof[SZ_W-1:0];
      sol_d = new_sol[SZ_W-1:0];
      sor_d = op_rot;
    end
    rv_d = accept;
    rf_d = rf_q;
    rd_d = rd_q;
    if (accept) begin
      rf_d = fault;
      rd_d = legal ? pfs_in : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sof_q <= '0;
      sol_q <= '0;
      sor_q <= '0;
    end else if (commit) begin
      sof_q <= sof_d;
      sol_q <= sol_d;
      sor_q <= sor_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rv_q <= 1'b0;
      rf_q <= '0;
      rd_q <= '0;
    end else begin
      rv_q <= rv_d;
      if (accept) begin
        rf_q <= rf_d;
        rd_q <= rd_d;
      end
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_fault = rf_q;
  assign rsp_dest  = rd_q;
  assign cfm_sof   = sof_q;
  assign cfm_sol   = sol_q;
  assign cfm_sor   = sor_q;
endmodule

// File: rtl/rsf_alloc_chk.sv
module rsf_alloc_chk #(
  parameter int SZ_W      = 7,
  parameter int MAX_FRAME = 96,
  parameter int ROT_GRAN  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            stall,
  input logic            rsp_valid,
  input logic [1:0]      rsp_fault,
  input logic [SZ_W-1:0] cfm_sof,
  input logic [SZ_W-1:0] cfm_sol,
  input logic [SZ_W-1:0] cfm_sor
);
  a_r8_fault_keeps_marker: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (cfm_sof == $past(cfm_sof) &&
      cfm_sol == $past(cfm_sol) && cfm_sor == $past(cfm_sor)));

  a_r9_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !req_ready);

  a_r9_marker_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> ($stable(cfm_sof) && $stable(cfm_sol) && $stable(cfm_sor)));

  a_r2_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready));

  a_r7_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'd3);

  a_r4_frame_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfm_sof) <= MAX_FRAME) && (cfm_sol <= cfm_sof) && (cfm_sor <= cfm_sof));

  a_r5_rot_multiple: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfm_sor) % ROT_GRAN) == 0);
endmodule

bind rsf_alloc rsf_alloc_chk #(
  .SZ_W(SZ_W), .MAX_FRAME(MAX_FRAME), .ROT_GRAN(ROT_GRAN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .stall     (stall),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .cfm_sof   (cfm_sof),
  .cfm_sol   (cfm_sol),
  .cfm_sor   (cfm_sor)
);

// File: tb/sim_rsf_alloc.sv
module sim_rsf_alloc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [6:0]  op_in = '0, op_loc = '0, op_out = '0, op_rot = '0;
  logic [5:0]  op_qp = '0;
  logic [37:0] pfs_in = '0;
  logic [6:0]  base_gr = '0, base_fr = '0;
  logic [5:0]  base_pr = '0;
  logic        spill_done = 1'b0;
  logic        stall, rsp_valid;
  logic [1:0]  rsp_fault;
  logic [37:0] rsp_dest;
  logic [6:0]  cfm_sof, cfm_sol, cfm_sor;
  logic [7:0]  free_regs;

  int checks = 0;
  int errors = 0;
  int m_sof = 0, m_sol = 0, m_sor = 0, m_free = 16;

  always #4 clk = ~clk;

  rsf_alloc u0 (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One request expected to go through without waiting; model updated from the rules.
  task automatic issue(input string req, input int i, input int l, input int o,
                       input int r, input int qp, input int exp_flt);
    longint pv;
    int nsof;
    @(negedge clk);
    pv = 64'h1000 + checks;
    op_in = 7'(i); op_loc = 7'(l); op_out = 7'(o); op_rot = 7'(r);
    op_qp = 6'(qp); pfs_in = 38'(pv); req_valid = 1'b1;
    #1;
    chk({req, " ready"}, req_ready, 1);
    chk({req, " no stall"}, stall, 0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    nsof = i + l + o;
    if (exp_flt == 0) begin
      m_free = m_free - ((nsof > m_sof) ? nsof - m_sof : 0) + ((m_sof > nsof) ? m_sof - nsof : 0);
      m_sof = nsof; m_sol = i + l; m_sor = r;
    end
    chk({req, " rsp_valid"}, rsp_valid, 1);
    chk({req, " fault code"}, rsp_fault, exp_flt);
    chk({req, " dest"}, rsp_dest, (exp_flt == 0) ? pv : 0);
    chk({req, " sof"}, cfm_sof, m_sof);
    chk({req, " sol"}, cfm_sol, m_sol);
    chk({req, " sor"}, cfm_sor, m_sor);
    chk({req, " free"}, free_regs, m_free);
    @(negedge clk);
    chk({req, " rsp one cycle"}, rsp_valid, 0);
  endtask

  task automatic t_reset;
    chk("R12 sof", cfm_sof, 0);
    chk("R12 sol", cfm_sol, 0);
    chk("R12 sor", cfm_sor, 0);
    chk("R12 free", free_regs, 16);
    chk("R12 rsp_valid", rsp_valid, 0);
    chk("R12 stall", stall, 0);
  endtask

  task automatic t_stall_then_spill;
    @(negedge clk);
    op_in = 7'd4; op_loc = 7'd8; op_out = 7'd8; op_rot = 7'd8; op_qp = '0;
    pfs_in = 38'h2abc; req_valid = 1'b1;
    #1;
    chk("R9 stall high", stall, 1);
    chk("R9 not ready", req_ready, 0);
    repeat (2) @(negedge clk);
    chk("R9 marker held", cfm_sof, 16);
    chk("R9 still stalled", stall, 1);
    for (int k = 0; k < 4; k++) begin
      spill_done = 1'b1;
      @(negedge clk);
      spill_done = 1'b0;
      #1;
      chk("R10 spill count", free_regs, k + 1);
      chk("R9 stall until fit", stall, (k < 3) ? 1 : 0);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 rsp after release", rsp_valid, 1);
    chk("R9 dest", rsp_dest, 38'h2abc);
    chk("R1 grown sof", cfm_sof, 20);
    chk("R1 grown sol", cfm_sol, 12);
    chk("R10 growth taken", free_regs, 0);
    m_sof = 20; m_sol = 12; m_sor = 8; m_free = 0;
  endtask

  task automatic t_legal_96_waits;
    @(negedge clk);
    op_in = 7'd32; op_loc = 7'd32; op_out = 7'd32; op_rot = 7'd8; op_qp = '0;
    req_valid = 1'b1;
    #1;
    chk("R4 96 legal stalls", stall, 1);
    chk("R4 96 not ready", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 no rsp while waiting", rsp_valid, 0);
    chk("R9 marker kept", cfm_sof, m_sof);
  endtask

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    issue("R1 first grow", 2, 3, 3, 8, 0, 0);
    issue("R10 grow exact", 4, 4, 8, 8, 0, 0);
    t_stall_then_spill();
    issue("R10 shrink", 0, 0, 8, 8, 0, 0);
    issue("R10 regrow", 4, 8, 8, 8, 0, 0);
    issue("R3 qp", 4, 8, 8, 8, 1, 1);
    issue("R4 over 96", 40, 40, 20, 8, 0, 1);
    issue("R5 uneven rot", 4, 8, 8, 12, 0, 1);
    issue("R5 rot over frame", 4, 8, 8, 24, 0, 1);
    t_legal_96_waits();
    base_gr = 7'd1;
    issue("R6 gr base", 4, 8, 8, 16, 0, 2);
    issue("R6 same rot ok", 4, 8, 8, 8, 0, 0);
    issue("R7 priority", 4, 8, 8, 16, 1, 1);
    issue("R8 fault with no free", 40, 40, 20, 16, 0, 1);
    base_gr = '0; base_fr = 7'd3;
    issue("R6 fr base", 4, 8, 8, 16, 0, 2);
    base_fr = '0; base_pr = 6'd2;
    issue("R6 pr base", 4, 8, 8, 0, 0, 2);
    base_pr = '0;
    issue("R11 empty frame", 0, 0, 0, 0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule